// File: doc/BRIEF.md
# Relocatable RAM with Write-Once Base

This block is a static RAM array that sits on a CPU bus and can be placed anywhere in the address space. Two small control registers steer it. A configuration register holds an access-privilege bit. A base register holds the upper address bits where the array sits. The base register accepts one write after reset and then locks. A stray write from runaway software therefore cannot move the array.

Each bus request carries an address, a transfer size (byte, word or long word), a direction and a supervisor flag. The block compares the address with the base. It then checks the privilege and the alignment, and either serves the transfer, flags an address error, or stays silent so that external logic can decode the cycle. A byte or word transfer takes one bus cycle of two clocks. A long word is split into two such bus cycles, one per word. A standby input freezes the array: nothing can read or write it.

Top module: `reloc_ram`

## Requirements
- R1: After reset, `ack` and `err` are low. The privilege bit reads 1 (supervisor only) and the base register reads 0. The array answers no address until the base register has been written.
- R2: Only the first write to the base register after reset takes effect. Every later write leaves it unchanged until the next reset.
- R3: A first base write that enables only one byte lane (`reg_be` bit 1 = bits 15:8, bit 0 = bits 7:0) still locks the register. The other lane then keeps its reset value of 0.
- R4: Base register bits 15:0 stand for address bits 23:8. An access hits when `addr[23:11]` equals base bits 15:3, and `addr[10:1]` selects the 16-bit word. A miss gets neither `ack` nor `err`.
- R5: Configuration bit 0 (`reg_sel`=0) set to 1 means supervisor only. In that mode a cycle with `sup`=0 gets no `ack` and no `err`, and it changes no data. With the bit at 0, user cycles are served.
- R6: A byte (`size`=0) or word (`size`=1) access raises `ack` for one clock, in the second clock after the request is taken.
- R7: A long-word access (`size`=2) raises `ack` once, in the fourth clock. The upper half of the data goes to the word at the addressed location and the lower half to the next word.
- R8: A word or long access at an odd address, or any access with `size`=3, raises `err` for one clock in the first clock after the request. There is no `ack` and no write.
- R9: While `stby` is high, array requests get no response and the array contents stay unchanged.
- R10: Storage is big-endian. The even byte of a word is bits 15:8. A byte write changes only its own lane. Reads return the addressed size right-aligned in `rdata` and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-clock strobe that starts a bus request |
| addr | input | 24 | Byte address |
| size | input | 2 | 0 byte, 1 word, 2 long word |
| wr | input | 1 | 1 write, 0 read |
| sup | input | 1 | 1 supervisor-mode cycle |
| wdata | input | 32 | Write data, right-aligned |
| rdata | output | 32 | Read data, valid while `ack` is high |
| ack | output | 1 | Transfer complete |
| err | output | 1 | Address error |
| stby | input | 1 | Standby: array access blocked |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 configuration, 1 base |
| reg_be | input | 2 | Byte lanes of the register write |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Selected register contents |

## Verification
The bench writes a single byte lane of the base first and then tries to fill the other lane. A design whose lock works per lane, or only on full-width writes, would end up with a different base. It checks that a long word spends exactly four clocks and lands big-endian across two words, so a design that completes it in one bus cycle or swaps the halves is caught. Misaligned and reserved-size requests must give `err` without touching the data. User cycles in supervisor-only mode, cycles during standby, and cycles before the base is written must all go unanswered, with stored data read back afterwards. A design that answered any of them, or wrote on them, would show up in those checks.

// File: rtl/reloc_ram.sv
module reloc_ram #(
  parameter int ADDR_W    = 24,
  parameter int RAM_BYTES = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              wr,
  input  logic              sup,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ack,
  output logic              err,
  input  logic              stby,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [1:0]        reg_be,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata
);
  localparam int IDX_W  = $clog2(RAM_BYTES);
  localparam int WI_W   = IDX_W - 1;
  localparam int WORDS  = RAM_BYTES / 2;
  localparam int BASE_W = ADDR_W - 8;

  logic              supo, locked, busy, bsel_q, err_q, wr_q;
  logic [BASE_W-1:0] base_q;
  logic [1:0]        phase, size_q;
  logic [WI_W-1:0]   widx_q, cur_idx;
  logic [31:0]       wdata_q;
  logic [15:0]       hi_q, rd_word, wr_word;
  logic [1:0]        wr_be;
  logic [15:0]       mem [WORDS];

  wire hit     = locked && (addr[ADDR_W-1:IDX_W] == base_q[BASE_W-1:IDX_W-8]);
  wire take    = req && !busy && hit && (sup || !supo) && !stby;
  wire bad     = (size == 2'd3) || (size != 2'd0 && addr[0]);
  wire start   = take && !bad;
  wire is_long = (size_q == 2'd2);

  assign ack       = busy && (phase == (is_long ? 2'd3 : 2'd1));
  assign err       = err_q;
  assign cur_idx   = widx_q + {{(WI_W-1){1'b0}}, phase[1]};
  assign rd_word   = mem[cur_idx];
  assign reg_rdata = reg_sel ? base_q : {15'd0, supo};

  always_comb begin
    wr_word = wdata_q[15:0];
    wr_be   = 2'b11;
    if (size_q == 2'd0) begin
      wr_word = {wdata_q[7:0], wdata_q[7:0]};
      wr_be   = bsel_q ? 2'b01 : 2'b10;
    end else if (is_long && !phase[1]) begin
      wr_word = wdata_q[31:16];
    end
  end

  always_comb begin
    if (is_long)              rdata = {hi_q, rd_word};
    else if (size_q == 2'd1)  rdata = {16'd0, rd_word};
    else                      rdata = {24'd0, bsel_q ? rd_word[7:0] : rd_word[15:8]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      supo   <= 1'b1;
      locked <= 1'b0;
      base_q <= '0;
    end else if (reg_we) begin
      if (!reg_sel) begin
        if (reg_be[0]) supo <= reg_wdata[0];
      end else if (!locked && reg_be != 2'b00) begin
        locked <= 1'b1;
        if (reg_be[1]) base_q[15:8] <= reg_wdata[15:8];
        if (reg_be[0]) base_q[7:0]  <= reg_wdata[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      err_q   <= 1'b0;
      phase   <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      bsel_q  <= 1'b0;
      widx_q  <= '0;
      wdata_q <= '0;
      hi_q    <= '0;
    end else begin
      err_q <= take && bad;
      if (start) begin
        busy    <= 1'b1;
        phase   <= '0;
        size_q  <= size;
        wr_q    <= wr;
        bsel_q  <= addr[0];
        widx_q  <= addr[IDX_W-1:1];
        wdata_q <= wdata;
      end else if (busy) begin
        phase <= phase + 2'd1;
        if (ack) busy <= 1'b0;
        if (phase == 2'd1) hi_q <= rd_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && wr_q && phase[0] && !stby) begin
      if (wr_be[1]) mem[cur_idx][15:8] <= wr_word[15:8];
      if (wr_be[0]) mem[cur_idx][7:0]  <= wr_word[7:0];
    end
  end

  AST_ACK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(ack && err)); // R8
  AST_BASE_FROZEN:  assert property (@(posedge clk) disable iff (!rst_n) locked && $past(locked) |-> $stable(base_q)); // R2
  AST_USER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) !busy && req && !sup && supo |=> !busy && !err); // R5
  AST_STBY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) !busy && stby |=> !busy && !err); // R9
  AST_SHORT_TWO:    assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) && size_q != 2'd2 |=> ack); // R6
  AST_ACK_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack); // R7
  AST_ERR_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) err |=> !err); // R8
endmodule

// File: tb/reloc_ram_bench.sv
`timescale 1ns/1ps
module reloc_ram_bench;
  logic        clk = 0, rst_n = 0, req = 0, wr = 0, sup = 0, stby = 0;
  logic        reg_we = 0, reg_sel = 0;
  logic [1:0]  size = 0, reg_be = 0;
  logic [23:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic        ack, err;
  int checks = 0, errors = 0;

  reloc_ram u_reloc_ram (.clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .size(size),
    .wr(wr), .sup(sup), .wdata(wdata), .rdata(rdata), .ack(ack), .err(err), .stby(stby),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic reg_write(input bit s, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_be = be; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_be = 0;
  endtask

  task automatic reg_read(input bit s, output logic [15:0] v);
    @(negedge clk); reg_sel = s; #1 v = reg_rdata;
  endtask

  task automatic bus(input logic [23:0] a, input logic [1:0] sz, input bit w, input bit s,
                     input logic [31:0] d, output int cyc, output bit e, output logic [31:0] rd);
    @(negedge clk); req = 1; addr = a; size = sz; wr = w; sup = s; wdata = d;
    @(negedge clk); req = 0;
    cyc = 0; e = 0; rd = 0;
    for (int i = 1; i <= 6; i++) begin
      if (i > 1) @(negedge clk);
      if (err) e = 1;
      if (ack && cyc == 0) begin cyc = i; rd = rdata; end
    end
  endtask

  task automatic t_reset;
    logic [15:0] v; int c; bit e; logic [31:0] rd;
    check(ack == 0 && err == 0, "R1 ack/err after reset", {30'd0, ack, err}, 0);
    reg_read(0, v); check(v == 16'd1, "R1 privilege reset", v, 1);
    reg_read(1, v); check(v == 16'd0, "R1 base reset", v, 0);
    bus(24'h000010, 2'd1, 0, 1, 0, c, e, rd);
    check(c == 0 && !e, "R1 no decode before base write", c, 0);
  endtask

  task automatic t_base_lock;
    logic [15:0] v;
    reg_write(1, 2'b01, 16'hAA08);
    reg_write(1, 2'b10, 16'h1200);
    reg_read(1, v); check(v == 16'h0008, "R3 half write locks other half", v, 16'h0008);
    reg_write(1, 2'b11, 16'h1234);
    reg_read(1, v); check(v == 16'h0008, "R2 later base write ignored", v, 16'h0008);
  endtask

  task automatic t_word_byte;
    int c; bit e; logic [31:0] rd;
    bus(24'h000810, 2'd1, 1, 1, 32'h0000BEEF, c, e, rd);
    check(c == 2 && !e, "R6 word write ack clock", c, 2);
    bus(24'h000810, 2'd1, 0, 1, 0, c, e, rd);
    check(c == 2 && rd == 32'h0000BEEF, "R4 word read back", rd, 32'h0000BEEF);
    bus(24'h000811, 2'd0, 1, 1, 32'hFFFFFF55, c, e, rd);
    check(c == 2, "R6 byte write ack clock", c, 2);
    bus(24'h000810, 2'd1, 0, 1, 0, c, e, rd);
    check(rd == 32'h0000BE55, "R10 byte write single lane", rd, 32'h0000BE55);
    bus(24'h000810, 2'd0, 0, 1, 0, c, e, rd);
    check(rd == 32'h000000BE, "R10 even byte read", rd, 32'h000000BE);
    bus(24'h000811, 2'd0, 0, 1, 0, c, e, rd);
    check(rd == 32'h00000055, "R10 odd byte read", rd, 32'h00000055);
  endtask

  task automatic t_long;
    int c; bit e; logic [31:0] rd;
    bus(24'h000820, 2'd2, 1, 1, 32'h11223344, c, e, rd);
    check(c == 4 && !e, "R7 long write ack clock", c, 4);
    bus(24'h000820, 2'd1, 0, 1, 0, c, e, rd);
    check(rd == 32'h00001122, "R7 upper half at address", rd, 32'h00001122);
    bus(24'h000822, 2'd1, 0, 1, 0, c, e, rd);
    check(rd == 32'h00003344, "R7 lower half next word", rd, 32'h00003344);
    bus(24'h000820, 2'd2, 0, 1, 0, c, e, rd);
    check(c == 4 && rd == 32'h11223344, "R7 long read", rd, 32'h11223344);
  endtask

  task automatic t_errors;
    int c; bit e; logic [31:0] rd;
    bus(24'h000811, 2'd1, 1, 1, 32'h0000DEAD, c, e, rd);
    check(e && c == 0, "R8 odd word gives err", {c[30:0], e}, 1);
    bus(24'h000821, 2'd2, 1, 1, 32'hDEADDEAD, c, e, rd);
    check(e && c == 0, "R8 odd long gives err", {c[30:0], e}, 1);
    bus(24'h000810, 2'd3, 1, 1, 32'hDEADDEAD, c, e, rd);
    check(e && c == 0, "R8 reserved size gives err", {c[30:0], e}, 1);
    bus(24'h000810, 2'd1, 0, 1, 0, c, e, rd);
    check(rd == 32'h0000BE55, "R8 error cycle wrote nothing", rd, 32'h0000BE55);
    bus(24'h001010, 2'd1, 0, 1, 0, c, e, rd);
    check(c == 0 && !e, "R4 miss outside base", c, 0);
  endtask

  task automatic t_priv;
    int c; bit e; logic [31:0] rd;
    bus(24'h000810, 2'd1, 1, 0, 32'h00000000, c, e, rd);
    check(c == 0 && !e, "R5 user cycle ignored", c, 0);
    bus(24'h000810, 2'd1, 0, 1, 0, c, e, rd);
    check(rd == 32'h0000BE55, "R5 user write had no effect", rd, 32'h0000BE55);
    reg_write(0, 2'b01, 16'h0000);
    bus(24'h000810, 2'd1, 0, 0, 0, c, e, rd);
    check(c == 2 && rd == 32'h0000BE55, "R5 user read allowed", rd, 32'h0000BE55);
  endtask

  task automatic t_standby;
    int c; bit e; logic [31:0] rd;
    stby = 1;
    bus(24'h000822, 2'd1, 1, 1, 32'h00007777, c, e, rd);
    check(c == 0 && !e, "R9 standby no response", c, 0);
    stby = 0;
    bus(24'h000822, 2'd1, 0, 1, 0, c, e, rd);
    check(rd == 32'h00003344, "R9 contents kept", rd, 32'h00003344);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_base_lock;
    t_word_byte;
    t_long;
    t_errors;
    t_priv;
    t_standby;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule